// File: doc/BRIEF.md
# Serial NCO Frequency Offset Loader

This block sets the tuning rate of a quadrature local oscillator. A carrier tracking loop outside the chip streams a frequency correction word into it one bit per clock. When a sync strobe marks the last bit, the block captures the collected word. The word is added to a center frequency that a microprocessor has programmed, and the sum becomes the phase increment of a numerically controlled oscillator (NCO). An enable bit sets whether the streamed correction counts at all. When the bit is clear, the oscillator runs at the center frequency alone.

The block also holds the NCO phase accumulator. Each clock it advances the accumulator by the current increment. The upper bits of the accumulator, plus a programmable phase offset, form the output phase. That phase feeds a sine/cosine stage placed downstream.

Top module: `nco_offset_loader`

## Requirements
- R1: While `rstN` is low, `phaseInc` and `phaseAcc` read zero, and `phaseOut` equals `phaseOffset`.
- R2: `serData` is sampled at every rising clock edge and shifted in most significant bit first. The word captured on a sync consists of the most recent FREQ_W bits, and the bit present in the cycle where `serSync` is high is the least significant bit. Bits older than that are discarded.
- R3: Once `serSync` has been sampled high, and with `offsetEn` high, `phaseInc` shows `centerFreq + word` modulo 2^FREQ_W from the second rising edge onward.
- R4: Serial bits shifted without a sync leave `phaseInc` unchanged.
- R5: With `offsetEn` low, `phaseInc` equals `centerFreq` one edge later. A word captured during that time is still kept. Setting `offsetEn` high again applies the kept word one edge later.
- R6: A change of `centerFreq` shows in `phaseInc` one edge later, without any sync.
- R7: At every rising edge out of reset, `phaseAcc` advances by the `phaseInc` value present before that edge, modulo 2^FREQ_W.
- R8: `phaseOut` equals the top PHASE_W bits of `phaseAcc` plus `phaseOffset`, modulo 2^PHASE_W, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serData | input | 1 | Serial correction bit, MSB first |
| serSync | input | 1 | High with the last bit of a word |
| offsetEn | input | 1 | Lets the serial correction into the increment |
| centerFreq | input | FREQ_W (32) | Programmed center frequency |
| phaseOffset | input | PHASE_W (10) | Programmed phase offset |
| phaseInc | output | FREQ_W (32) | NCO phase increment |
| phaseAcc | output | FREQ_W (32) | NCO phase accumulator |
| phaseOut | output | PHASE_W (10) | Offset output phase |

## Verification
A wrong bit in the shift register stays hidden until the next sync. Two edges after that sync, the error shows in `phaseInc` as a wrong sum. A bit order that is reversed or shifted by one position changes the walking-one offsets at once. A wrong held word or a wrong enable gate shows at the port one edge after the control input that exposes it. An accumulator fault shows on the very next edge as a step that differs from the observed increment. After that, the same fault also appears in `phaseOut`.

// File: rtl/nco_ldr_pkg.sv
package nco_ldr_pkg;
  typedef struct packed {
    logic shiftBit;
    logic latchWord;
    logic gateOffset;
  } ldrStrobes_t;
endpackage

// File: rtl/nco_ldr_ctrl.sv
module nco_ldr_ctrl
  import nco_ldr_pkg::*;
(
  input  logic        serSync,
  input  logic        offsetEn,
  output ldrStrobes_t strobes
);
  // One serial bit arrives on every clock, so shifting never pauses.
  always_comb begin
    strobes.shiftBit   = 1'b1;
    strobes.latchWord  = serSync;
    strobes.gateOffset = offsetEn;
  end
endmodule

// File: rtl/nco_ldr_dp.sv
module nco_ldr_dp
  import nco_ldr_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serData,
  input  ldrStrobes_t        strobes,
  input  logic [FREQ_W-1:0]  centerFreq,
  input  logic [PHASE_W-1:0] phaseOffset,
  output logic [FREQ_W-1:0]  phaseInc,
  output logic [FREQ_W-1:0]  phaseAcc,
  output logic [PHASE_W-1:0] phaseOut
);
  localparam int TOP_LSB = FREQ_W - PHASE_W;

  logic [FREQ_W-1:0] shiftWord;
  logic [FREQ_W-1:0] nextShift;
  logic [FREQ_W-1:0] holdWord;
  logic [FREQ_W-1:0] offsetTerm;

  assign nextShift  = {shiftWord[FREQ_W-2:0], serData};
  assign offsetTerm = strobes.gateOffset ? holdWord : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftWord <= '0;
    else if (strobes.shiftBit) shiftWord <= nextShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdWord <= '0;
    else if (strobes.latchWord) holdWord <= nextShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseInc <= '0;
    else phaseInc <= centerFreq + offsetTerm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseAcc <= '0;
    else phaseAcc <= phaseAcc + phaseInc;
  end

  assign phaseOut = phaseAcc[FREQ_W-1:TOP_LSB] + phaseOffset;
endmodule

// File: rtl/nco_offset_loader.sv
module nco_offset_loader
  import nco_ldr_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serData,
  input  logic               serSync,
  input  logic               offsetEn,
  input  logic [FREQ_W-1:0]  centerFreq,
  input  logic [PHASE_W-1:0] phaseOffset,
  output logic [FREQ_W-1:0]  phaseInc,
  output logic [FREQ_W-1:0]  phaseAcc,
  output logic [PHASE_W-1:0] phaseOut
);
  ldrStrobes_t strobes;

  nco_ldr_ctrl u_ctrl (
    .serSync (serSync),
    .offsetEn(offsetEn),
    .strobes (strobes)
  );

  nco_ldr_dp #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .serData    (serData),
    .strobes    (strobes),
    .centerFreq (centerFreq),
    .phaseOffset(phaseOffset),
    .phaseInc   (phaseInc),
    .phaseAcc   (phaseAcc),
    .phaseOut   (phaseOut)
  );
endmodule

// File: rtl/nco_ldr_checker.sv
module nco_ldr_checker #(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               serSync,
  input logic               offsetEn,
  input logic [FREQ_W-1:0]  centerFreq,
  input logic [PHASE_W-1:0] phaseOffset,
  input logic [FREQ_W-1:0]  phaseInc,
  input logic [FREQ_W-1:0]  phaseAcc,
  input logic [PHASE_W-1:0] phaseOut
);
  logic [PHASE_W-1:0] accTop;
  assign accTop = phaseAcc[FREQ_W-1:FREQ_W-PHASE_W];

  p_acc_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> phaseAcc == $past(phaseAcc) + $past(phaseInc));

  p_center_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(offsetEn)) |-> phaseInc == $past(centerFreq));

  p_hold_no_sync_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 2) && !$past(serSync, 2) &&
     $past(centerFreq) == $past(centerFreq, 2) &&
     $past(offsetEn) == $past(offsetEn, 2)) |-> $stable(phaseInc));

  p_phase_track_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $stable(phaseOffset)) |->
      PHASE_W'(phaseOut - $past(phaseOut)) == PHASE_W'(accTop - $past(accTop)));
endmodule

bind nco_offset_loader nco_ldr_checker #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .serSync    (serSync),
  .offsetEn   (offsetEn),
  .centerFreq (centerFreq),
  .phaseOffset(phaseOffset),
  .phaseInc   (phaseInc),
  .phaseAcc   (phaseAcc),
  .phaseOut   (phaseOut)
);

// File: tb/sim_nco_offset_loader.sv
module sim_nco_offset_loader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serData = 1'b0;
  logic        serSync = 1'b0;
  logic        offsetEn = 1'b1;
  logic [31:0] centerFreq = '0;
  logic [9:0]  phaseOffset = 10'h155;
  logic [31:0] phaseInc;
  logic [31:0] phaseAcc;
  logic [9:0]  phaseOut;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nco_offset_loader u0 (
    .clk(clk), .rstN(rstN), .serData(serData), .serSync(serSync),
    .offsetEn(offsetEn), .centerFreq(centerFreq), .phaseOffset(phaseOffset),
    .phaseInc(phaseInc), .phaseAcc(phaseAcc), .phaseOut(phaseOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Stream a word MSB first, sync on the last bit, wait until phaseInc shows it.
  task automatic sendWord(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk);
      serData = w[i];
      serSync = (i == 0);
    end
    @(negedge clk);
    serSync = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] held;
    logic [31:0] prevAcc;
    logic [31:0] prevInc;
    repeat (3) @(negedge clk);
    chk("R1 inc", phaseInc, 32'h0);
    chk("R1 acc", phaseAcc, 32'h0);
    chk("R1 out", {22'h0, phaseOut}, 32'h155);
    rstN = 1'b1;

    // R2/R3: walking-one offsets
    centerFreq = 32'h1000_0000;
    for (int b = 0; b < 32; b++) begin
      sendWord(32'h1 << b);
      chk("R2/R3 walk", phaseInc, 32'h1000_0000 + (32'h1 << b));
    end
    // R3 wrap and negative offset
    centerFreq = 32'hFFFF_FFF0;
    sendWord(32'h0000_0020);
    chk("R3 wrap", phaseInc, 32'h0000_0010);
    centerFreq = 32'h4000_0000;
    sendWord(32'hFFFF_FF00);
    chk("R3 neg", phaseInc, 32'h3FFF_FF00);

    // R2: older bits dropped
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      serData = 1'b1;
    end
    sendWord(32'h00A5_5A00);
    chk("R2 prefix", phaseInc, 32'h40A5_5A00);
    held = 32'h00A5_5A00;

    // R4: shifting without sync
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      serData = i[0] ^ i[2];
      chk("R4 nosync", phaseInc, 32'h4000_0000 + held);
    end

    // R5: gate off, capture while off, re-enable
    @(negedge clk);
    offsetEn = 1'b0;
    @(negedge clk);
    chk("R5 off", phaseInc, 32'h4000_0000);
    sendWord(32'h0000_1234);
    chk("R5 off sync", phaseInc, 32'h4000_0000);
    offsetEn = 1'b1;
    @(negedge clk);
    chk("R5 reenable", phaseInc, 32'h4000_1234);
    held = 32'h0000_1234;

    // R6: center change
    centerFreq = 32'h2222_2222;
    @(negedge clk);
    chk("R6 center", phaseInc, 32'h2222_2222 + held);

    // R7: accumulator stepping, vary increment
    centerFreq = 32'hF000_0000;
    prevAcc = phaseAcc;
    prevInc = phaseInc;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      chk("R7 acc", phaseAcc, prevAcc + prevInc);
      prevAcc = phaseAcc;
      prevInc = phaseInc;
      if (i == 150) centerFreq = 32'h0123_4567;
    end

    // R8: sweep every phase offset
    for (int v = 0; v < 1024; v++) begin
      @(negedge clk);
      phaseOffset = v[9:0];
      #1;
      chk("R8 out", {22'h0, phaseOut}, {22'h0, phaseAcc[31:22] + v[9:0]});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule